// File: doc/BRIEF.md
# Nonvolatile Memory Write-Protect Control Register

This block is the control register and write-gating logic in front of a small byte-addressed nonvolatile array. It sees one decoded request per cycle from a serial bus engine. A request carries a 16-bit address, a data byte and a read/write flag. The top address (FFFFh) selects the 8-bit control register and every other address selects the array. The block decides whether each write is taken or dropped. It keeps two volatile enable latches, and it also keeps a lock bit, a watchdog period field and a protect-range field, which are held in flops that reset to factory values.

Register writes pass through a two-step enable. A first write of 02h opens the write latch and a write of 06h arms the register latch. Only after those two writes can one write replace the lock, watchdog and protect fields. An external write-protect pin combined with the sticky lock bit freezes the protect field and the lock bit itself. While that lock is active, the watchdog field stays writable and the unprotected part of the array stays open.

Top module: `wp_ctrl_reg`

## Requirements
- R1: After reset the register reads 60h: lock=0, watchdog code=11 (disabled), protect code=000, both latches 0. wdPeriod is 11 and no pulse is output.
- R2: A read request at FFFFh pulses rdValid in the cycle after the request, with rdData set to the register byte. Bit 7 is the lock, bits 6:5 the watchdog code, bit 4 protect[1], bit 3 protect[0], bit 2 the register latch, bit 1 the write latch and bit 0 protect[2]. A read at any other address gives no rdValid.
- R3: While the write latch is 0, every write is rejected except a register write of 02h. That write sets the write latch and is granted.
- R4: A register write of 00h while the write latch is 1 is granted and clears both latches. Array writes are rejected afterwards.
- R5: A register write of 06h while the write latch is 1 sets the register latch. With the register latch at 0, a field-update write (any value other than 00h, 02h or 06h) is rejected and changes nothing.
- R6: With both latches set, a field-update write is granted. It loads the lock from bit 7, the watchdog code from bits 6:5 and the protect code from {bit 0, bit 4, bit 3}. It then clears the register latch and leaves the write latch at 1.
- R7: The protect code guards addresses from 000h up to a limit, and writes inside that range are rejected. The codes are 000 none, 001 64 bytes, 010 128 bytes, 011 256 bytes, 100 512 bytes and 101 the whole 4K array. Codes 110 and 111 guard nothing.
- R8: An array write to an address at or above 1000h (other than FFFFh) is rejected.
- R9: While wpPin=1 and the lock is 1, a field-update write leaves the protect code and the lock unchanged but still loads the watchdog code. Protected addresses stay rejected and unprotected ones stay granted. With wpPin=0 the lock can be cleared.
- R10: wdPeriod always equals the stored watchdog code: 00 1.4 s, 01 600 ms, 10 200 ms, 11 disabled.
- R11: Every write request produces exactly one of writeGrant or writeReject, as a one-cycle pulse in the cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe; address, data and flag are sampled with it |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 16 | Byte address; FFFFh is the register |
| reqData | input | 8 | Write data |
| wpPin | input | 1 | Hardware write-protect pin |
| writeGrant | output | 1 | Write accepted pulse |
| writeReject | output | 1 | Write ignored pulse |
| rdValid | output | 1 | Register read data valid |
| rdData | output | 8 | Register byte |
| wdPeriod | output | 2 | Watchdog period code |

## Verification
The bench walks through every protect code and probes the last protected byte and the first open byte of each range. A decoder that is off by one block or one address would grant a guarded byte or refuse an open one. It checks that the 02h, 06h and 00h exceptions act only on exact values. A design that treated any write with bit 1 set as an enable, or that let a field update through without the register latch, would show a wrong readback byte. It holds the pin high with the lock set and tries to clear both the lock and the protect code. A design that gated only the protect bits would drop the lock, and one that gated the whole register would fail to move the watchdog code.

// File: rtl/wpc_pkg.sv
package wpc_pkg;

  localparam int REG_W = 8;

  // register bit positions (readback layout)
  localparam int BIT_LOCK  = 7;
  localparam int BIT_WD_HI = 6;
  localparam int BIT_WD_LO = 5;
  localparam int BIT_PR1   = 4;
  localparam int BIT_PR0   = 3;
  localparam int BIT_RLAT  = 2;
  localparam int BIT_WLAT  = 1;
  localparam int BIT_PR2   = 0;

  localparam logic [REG_W-1:0] CODE_WLAT_SET = 8'h02;
  localparam logic [REG_W-1:0] CODE_RLAT_SET = 8'h06;
  localparam logic [REG_W-1:0] CODE_CLEAR    = 8'h00;

  localparam logic [1:0] WD_RESET = 2'b11;

  typedef struct packed {
    logic       lock;
    logic [1:0] wd;
    logic [2:0] prot;
    logic       rLatch;
    logic       wLatch;
  } wpcState_t;

  typedef struct packed {
    logic setWLatch;
    logic clrLatches;
    logic setRLatch;
    logic loadFields;
    logic loadProt;
    logic readReg;
  } wpcStrobe_t;

endpackage

// File: rtl/wpc_datapath.sv
module wpc_datapath
  import wpc_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int ARRAY_BYTES = 4096,
  parameter int BLK_BYTES   = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  wpcStrobe_t        strobe,
  input  logic [REG_W-1:0]  wrData,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wpPin,
  output wpcState_t         state,
  output logic              hwLock,
  output logic              protHit,
  output logic              inArray,
  output logic [REG_W-1:0]  rdData
);

  localparam int CMP_W = ADDR_W + 1;

  logic       lockQ, rLatchQ, wLatchQ;
  logic [1:0] wdQ;
  logic [2:0] protQ;
  logic [CMP_W-1:0] protLimit;

  assign hwLock = wpPin & lockQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lockQ   <= 1'b0;
      wdQ     <= WD_RESET;
      protQ   <= 3'b000;
      rLatchQ <= 1'b0;
      wLatchQ <= 1'b0;
    end else begin
      if (strobe.setWLatch) wLatchQ <= 1'b1;
      if (strobe.setRLatch) rLatchQ <= 1'b1;
      if (strobe.clrLatches) begin
        wLatchQ <= 1'b0;
        rLatchQ <= 1'b0;
      end
      if (strobe.loadFields) begin
        wdQ     <= {wrData[BIT_WD_HI], wrData[BIT_WD_LO]};
        rLatchQ <= 1'b0;
      end
      if (strobe.loadProt) begin
        lockQ <= wrData[BIT_LOCK];
        protQ <= {wrData[BIT_PR2], wrData[BIT_PR1], wrData[BIT_PR0]};
      end
    end
  end

  // protected range decode: codes 1..4 double from one block, 5 covers all
  always_comb begin
    protLimit = '0;
    for (int k = 1; k <= 4; k++) begin
      if (protQ == 3'(k)) protLimit = CMP_W'(BLK_BYTES) << (k - 1);
    end
    if (protQ == 3'd5) protLimit = CMP_W'(ARRAY_BYTES);
  end

  assign protHit = ({1'b0, addr} < protLimit);
  assign inArray = ({1'b0, addr} < CMP_W'(ARRAY_BYTES));

  always_ff @(posedge clk) begin
    if (!rstN) rdData <= '0;
    else if (strobe.readReg) begin
      rdData[BIT_LOCK]  <= lockQ;
      rdData[BIT_WD_HI] <= wdQ[1];
      rdData[BIT_WD_LO] <= wdQ[0];
      rdData[BIT_PR1]   <= protQ[1];
      rdData[BIT_PR0]   <= protQ[0];
      rdData[BIT_RLAT]  <= rLatchQ;
      rdData[BIT_WLAT]  <= wLatchQ;
      rdData[BIT_PR2]   <= protQ[2];
    end
  end

  assign state = '{lock: lockQ, wd: wdQ, prot: protQ,
                   rLatch: rLatchQ, wLatch: wLatchQ};

  AST_LOCK_FREEZES: assert property (@(posedge clk) disable iff (!rstN)
    hwLock |=> ($stable(protQ) && $stable(lockQ))) else $error("lock"); // R9

  AST_WD_NEEDS_RLATCH: assert property (@(posedge clk) disable iff (!rstN)
    (wdQ != $past(wdQ)) |-> $past(rLatchQ && wLatchQ)) else $error("wd"); // R6

endmodule

// File: rtl/wpc_control.sv
module wpc_control
  import wpc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] REG_ADDR = '1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [REG_W-1:0]  reqData,
  input  wpcState_t         state,
  input  logic              hwLock,
  input  logic              protHit,
  input  logic              inArray,
  output wpcStrobe_t        strobe,
  output logic              writeGrant,
  output logic              writeReject,
  output logic              rdValid
);

  logic isReg, grantNext, rejectNext;

  assign isReg = (reqAddr == REG_ADDR);

  always_comb begin
    strobe     = '0;
    grantNext  = 1'b0;
    rejectNext = 1'b0;
    if (reqValid && !reqWrite) begin
      strobe.readReg = isReg;
    end else if (reqValid && reqWrite) begin
      if (isReg) begin
        if (reqData == CODE_WLAT_SET) begin
          strobe.setWLatch = 1'b1;
          grantNext        = 1'b1;
        end else if (!state.wLatch) begin
          rejectNext = 1'b1;
        end else if (reqData == CODE_CLEAR) begin
          strobe.clrLatches = 1'b1;
          grantNext         = 1'b1;
        end else if (reqData == CODE_RLAT_SET) begin
          strobe.setRLatch = 1'b1;
          grantNext        = 1'b1;
        end else if (state.rLatch) begin
          strobe.loadFields = 1'b1;
          strobe.loadProt   = !hwLock;
          grantNext         = 1'b1;
        end else begin
          rejectNext = 1'b1;
        end
      end else begin
        if (state.wLatch && inArray && !protHit) grantNext = 1'b1;
        else rejectNext = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      writeGrant  <= 1'b0;
      writeReject <= 1'b0;
      rdValid     <= 1'b0;
    end else begin
      writeGrant  <= grantNext;
      writeReject <= rejectNext;
      rdValid     <= strobe.readReg;
    end
  end

  AST_ONE_DECISION: assert property (@(posedge clk) disable iff (!rstN)
    !(writeGrant && writeReject)) else $error("both"); // R11

  AST_WRITE_ANSWERED: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqWrite) |=> (writeGrant || writeReject)) else $error("ans"); // R11

  AST_LATCH_GATE: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqWrite && !state.wLatch && reqData != CODE_WLAT_SET)
      |=> writeReject) else $error("gate"); // R3

  AST_RANGE_BLOCK: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqWrite && !isReg && protHit) |=> writeReject)
    else $error("range"); // R7

  AST_READ_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> $past(reqValid && !reqWrite && isReg)) else $error("rd"); // R2

endmodule

// File: rtl/wp_ctrl_reg.sv
module wp_ctrl_reg
  import wpc_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int ARRAY_BYTES = 4096,
  parameter int BLK_BYTES   = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [7:0]        reqData,
  input  logic              wpPin,
  output logic              writeGrant,
  output logic              writeReject,
  output logic              rdValid,
  output logic [7:0]        rdData,
  output logic [1:0]        wdPeriod
);

  wpcStrobe_t strobe;
  wpcState_t  state;
  logic       hwLock, protHit, inArray;

  wpc_control #(.ADDR_W(ADDR_W), .REG_ADDR('1)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqData(reqData), .state(state), .hwLock(hwLock),
    .protHit(protHit), .inArray(inArray), .strobe(strobe),
    .writeGrant(writeGrant), .writeReject(writeReject), .rdValid(rdValid)
  );

  wpc_datapath #(.ADDR_W(ADDR_W), .ARRAY_BYTES(ARRAY_BYTES),
                 .BLK_BYTES(BLK_BYTES)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(reqData),
    .addr(reqAddr), .wpPin(wpPin), .state(state), .hwLock(hwLock),
    .protHit(protHit), .inArray(inArray), .rdData(rdData)
  );

  assign wdPeriod = state.wd;

endmodule

// File: tb/tb_wp_ctrl_reg.sv
module tb_wp_ctrl_reg;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0, wpPin = 1'b0;
  logic [15:0] reqAddr = '0;
  logic [7:0]  reqData = '0;
  logic        writeGrant, writeReject, rdValid;
  logic [7:0]  rdData;
  logic [1:0]  wdPeriod;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;

  // expected item: {grant, reject, rdValid, rdData}
  logic [10:0] expQ[$];
  string       tagQ[$];

  always #4 clk = ~clk;

  wp_ctrl_reg dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqData(reqData), .wpPin(wpPin),
    .writeGrant(writeGrant), .writeReject(writeReject), .rdValid(rdValid),
    .rdData(rdData), .wdPeriod(wdPeriod)
  );

  // monitor: pops one expectation per request, else expects silence
  always @(posedge clk) begin
    #2;
    cycles++;
    if (rstN) begin
      logic [10:0] got, exp;
      string tag;
      got = {writeGrant, writeReject, rdValid, rdValid ? rdData : 8'h00};
      if (expQ.size() > 0) begin
        exp = expQ.pop_front();
        tag = tagQ.pop_front();
      end else begin
        exp = '0;
        tag = "R11 idle";
      end
      checks++;
      if (got !== exp) begin
        failures++;
        $display("FAIL %s: got g/r/v/d=%b/%b/%b/%h expected %b/%b/%b/%h",
                 tag, got[10], got[9], got[8], got[7:0],
                 exp[10], exp[9], exp[8], exp[7:0]);
      end
    end
  end

  task automatic doWrite(input logic [15:0] a, input logic [7:0] d,
                         input bit grant, input string tag);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = a; reqData = d;
    expQ.push_back({grant, !grant, 1'b0, 8'h00});
    tagQ.push_back(tag);
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic doRead(input logic [15:0] a, input bit valid,
                        input logic [7:0] d, input string tag);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b0; reqAddr = a; reqData = 8'h00;
    expQ.push_back({1'b0, 1'b0, valid, valid ? d : 8'h00});
    tagQ.push_back(tag);
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic checkWd(input logic [1:0] e, input string tag);
    @(negedge clk);
    checks++;
    if (wdPeriod !== e) begin
      failures++;
      $display("FAIL %s: wdPeriod=%b expected %b", tag, wdPeriod, e);
    end
  endtask

  task automatic loadFields(input logic [7:0] d, input string tag);
    doWrite(16'hFFFF, 8'h06, 1'b1, "R5 arm");
    doWrite(16'hFFFF, d, 1'b1, tag);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    checkWd(2'b11, "R1 wd reset");
    doRead(16'hFFFF, 1'b1, 8'h60, "R1 reset readback");
    doRead(16'h0010, 1'b0, 8'h00, "R2 read elsewhere");
    // R3 latch gate
    doWrite(16'h0100, 8'h55, 1'b0, "R3 array no latch");
    doWrite(16'hFFFF, 8'h06, 1'b0, "R3 06 no latch");
    doWrite(16'hFFFF, 8'h00, 1'b0, "R3 00 no latch");
    doRead(16'hFFFF, 1'b1, 8'h60, "R3 unchanged");
    doWrite(16'hFFFF, 8'h02, 1'b1, "R3 set latch");
    doRead(16'hFFFF, 1'b1, 8'h62, "R2 latch readback");
    doWrite(16'h0100, 8'hAA, 1'b1, "R3 array open");
    // R5 field write without register latch
    doWrite(16'hFFFF, 8'hA0, 1'b0, "R5 no rlatch");
    doRead(16'hFFFF, 1'b1, 8'h62, "R5 unchanged");
    doWrite(16'hFFFF, 8'h06, 1'b1, "R5 arm");
    doRead(16'hFFFF, 1'b1, 8'h66, "R5 rlatch set");
    // R6/R7 code 001, wd 01
    doWrite(16'hFFFF, 8'h28, 1'b1, "R6 load");
    doRead(16'hFFFF, 1'b1, 8'h2A, "R6 readback");
    checkWd(2'b01, "R10 wd 01");
    doWrite(16'h003F, 8'h00, 1'b0, "R7 64 edge in");
    doWrite(16'h0040, 8'h00, 1'b1, "R7 64 edge out");
    // code 010, wd 00
    loadFields(8'h10, "R6 load 010");
    doRead(16'hFFFF, 1'b1, 8'h12, "R6 readback 010");
    checkWd(2'b00, "R10 wd 00");
    doWrite(16'h007F, 8'h00, 1'b0, "R7 128 in");
    doWrite(16'h0080, 8'h00, 1'b1, "R7 128 out");
    loadFields(8'h18, "R6 load 011");
    doWrite(16'h00FF, 8'h00, 1'b0, "R7 256 in");
    doWrite(16'h0100, 8'h00, 1'b1, "R7 256 out");
    loadFields(8'h01, "R6 load 100");
    doWrite(16'h01FF, 8'h00, 1'b0, "R7 512 in");
    doWrite(16'h0200, 8'h00, 1'b1, "R7 512 out");
    loadFields(8'h09, "R6 load 101");
    doWrite(16'h0FFF, 8'h00, 1'b0, "R7 full top");
    doWrite(16'h0000, 8'h00, 1'b0, "R7 full bottom");
    loadFields(8'h11, "R6 load 110");
    doWrite(16'h0000, 8'h00, 1'b1, "R7 code 110 none");
    loadFields(8'h19, "R6 load 111");
    doWrite(16'h0000, 8'h00, 1'b1, "R7 code 111 none");
    // R8 outside the array
    doWrite(16'h1000, 8'h00, 1'b0, "R8 above array");
    doWrite(16'hFFFE, 8'h00, 1'b0, "R8 top minus one");
    // R9 hardware lock
    loadFields(8'hC8, "R9 set lock");
    doRead(16'hFFFF, 1'b1, 8'hCA, "R9 lock readback");
    checkWd(2'b10, "R10 wd 10");
    wpPin = 1'b1;
    loadFields(8'h60, "R9 locked load");
    doRead(16'hFFFF, 1'b1, 8'hEA, "R9 frozen prot/lock");
    checkWd(2'b11, "R9 wd still loads");
    doWrite(16'h0020, 8'h00, 1'b0, "R9 protected");
    doWrite(16'h0040, 8'h00, 1'b1, "R9 unprotected");
    wpPin = 1'b0;
    loadFields(8'h60, "R9 unlock");
    doRead(16'hFFFF, 1'b1, 8'h62, "R9 unlocked readback");
    // R4 clear
    doWrite(16'hFFFF, 8'h06, 1'b1, "R4 arm");
    doWrite(16'hFFFF, 8'h00, 1'b1, "R4 clear");
    doRead(16'hFFFF, 1'b1, 8'h60, "R4 cleared readback");
    doWrite(16'h0100, 8'h00, 1'b0, "R4 array after clear");
    doWrite(16'hFFFF, 8'h02, 1'b1, "R4 reopen");
    doWrite(16'hFFFF, 8'h20, 1'b0, "R4 rlatch was cleared");
    doRead(16'hFFFF, 1'b1, 8'h62, "R4 final readback");
    repeat (4) @(negedge clk);
    done = 1'b1;
  end

  initial begin
    wait (done || cycles > 20000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: run did not finish, expected completion");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule